// File: doc/BRIEF.md
# Sequential Stream Line Prefetcher

The block observes demand read requests from the first-level caches, each given as a physical cache-line address (the byte address divided by 64). When two consecutive demands touch adjacent lines in the same 4 KB page, it opens a stream in that page in the direction of the step. A later demand that lands on the next line of the stream makes the block issue up to two prefetch requests for the lines after its prefetch pointer, one line at a time, and never leaves the page.

How far the prefetch pointer may run ahead of demand depends on the number of outstanding requests reported by the core. Under light load it may lead by 20 lines, under moderate load by 10, and under heavy load by 4. Under heavy load, and for any line more than 10 lines ahead, the request is marked for the last-level cache only. Up to 32 streams are held in a table, at most one per page and direction. When the table is full, the least recently used stream is replaced.

Prefetch requests leave through a valid/ready port, one per cycle. A second request from the same demand waits in a one-entry holding register. Candidates that find no room are dropped, and the stream pointer is not advanced past them.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `pf_valid` is 0, the stream table is empty, and no previous demand is remembered, so a demand adjacent to one seen before reset opens no stream.
- R2: A demand whose line is one above (or one below) the previous demand, in the same 4 KB page (line address bits [29:6] equal), opens an ascending (or descending) stream for that page and direction. The opening demand is itself treated as a stream hit. An isolated or non-adjacent demand issues nothing.
- R3: A demand on the line one step beyond a stream's last demand line, in the stream's direction, is a hit. It issues up to two prefetches for the lines immediately after the greater (ascending) or smaller (descending) of the stream's prefetch pointer and the demand line.
- R4: No prefetch address leaves the page of the demand that caused it: offsets stay within 0..63.
- R5: The distance of a prefetch is the line difference from the demand that caused it. With `outst_cnt` below 4 the distance is at most 20, from 4 to 11 at most 10, and at 12 or more at most 4. A candidate over the limit is not issued, and the stream waits until demand advances.
- R6: `pf_llc_only` is 1 (last-level cache only) when `outst_cnt` is 12 or more, or when the distance exceeds 10. Otherwise it is 0 (mid-level and last-level).
- R7: One page may hold an ascending and a descending stream at the same time. Each advances independently.
- R8: The table holds 32 streams. Opening a stream when it is full replaces the stream touched least recently; streams touched since then survive.
- R9: While `pf_valid` is 1 and `pf_ready` is 0, the request on the port stays unchanged. A second request waits in a holding register. Candidates that find both slots full are dropped, and the stream pointer does not move past them.
- R10: The first prefetch for a demand is on the port in the cycle after the clock edge that samples the demand. The second follows one accepted transfer later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dmd_valid | input | 1 | A demand read is presented this cycle |
| dmd_line | input | 30 | Physical line address of the demand |
| outst_cnt | input | 6 | Number of outstanding requests of the core |
| pf_valid | output | 1 | A prefetch request is presented |
| pf_ready | input | 1 | The consumer takes the presented request |
| pf_line | output | 30 | Physical line address to prefetch |
| pf_llc_only | output | 1 | 1: last-level cache only; 0: mid-level and last-level |

## Verification
A demand changes the stream table and the output registers at the same edge that samples it, so its first prefetch is due one cycle later and the second one accepted transfer after that. The bench drives every input on the falling edge and reads the port at the falling edge right after the sampling edge. It then keeps reading for three more cycles with the port ready, so every request caused by the demand has drained before the next demand starts. In the backpressure case the port is held not ready for several cycles and read at every falling edge, to confirm the request holds still and no third request appears.

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
  parameter int LINE_W     = 30,
  parameter int PAGE_LINES = 64,
  parameter int STREAMS    = 32,
  parameter int CNT_W      = 6,
  parameter int LOAD_MOD   = 4,
  parameter int LOAD_HEAVY = 12,
  parameter int DIST_LIGHT = 20,
  parameter int DIST_MOD   = 10,
  parameter int DIST_HEAVY = 4,
  parameter int FAR_LINES  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dmd_valid,
  input  logic [LINE_W-1:0] dmd_line,
  input  logic [CNT_W-1:0]  outst_cnt,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [LINE_W-1:0] pf_line,
  output logic              pf_llc_only
);
  localparam int OFF_W = $clog2(PAGE_LINES);
  localparam int PG_W  = LINE_W - OFF_W;
  localparam int IDX_W = $clog2(STREAMS);
  localparam int AGE_W = IDX_W + 2;
  localparam int W     = OFF_W + 2;
  localparam logic [W-1:0] TOP   = W'(PAGE_LINES - 1);
  localparam logic [W-1:0] LIM_L = W'(DIST_LIGHT);
  localparam logic [W-1:0] LIM_M = W'(DIST_MOD);
  localparam logic [W-1:0] LIM_H = W'(DIST_HEAVY);
  localparam logic [W-1:0] FAR   = W'(FAR_LINES);
  localparam logic [W-1:0] ONE   = W'(1);
  localparam logic [W-1:0] TWO   = W'(2);
  localparam logic [CNT_W-1:0] THR_M = CNT_W'(LOAD_MOD);
  localparam logic [CNT_W-1:0] THR_H = CNT_W'(LOAD_HEAVY);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic             t_val [STREAMS];
  logic [PG_W-1:0]  t_pg  [STREAMS];
  logic             t_dir [STREAMS];
  logic [OFF_W-1:0] t_dem [STREAMS];
  logic [OFF_W-1:0] t_ptr [STREAMS];
  logic [AGE_W-1:0] t_age [STREAMS];

  logic              last_v;
  logic [LINE_W-1:0] last_line;
  logic              q_v0, q_v1, q_l0, q_l1;
  logic [LINE_W-1:0] q_ln0, q_ln1;

  logic [PG_W-1:0] d_pg;
  logic [W-1:0]    d_off, l_off;
  logic            same_pg, adj_up, adj_dn;
  assign d_pg    = dmd_line[LINE_W-1:OFF_W];
  assign d_off   = {2'b00, dmd_line[OFF_W-1:0]};
  assign l_off   = {2'b00, last_line[OFF_W-1:0]};
  assign same_pg = last_v && (last_line[LINE_W-1:OFF_W] == d_pg);
  assign adj_up  = same_pg && (l_off + ONE == d_off);
  assign adj_dn  = same_pg && (d_off + ONE == l_off);

  logic             hit_any, ex_any, free_any;
  logic [IDX_W-1:0] hit_idx, ex_idx, free_idx, old_idx;
  logic [AGE_W-1:0] old_age;

  always_comb begin
    hit_any = 1'b0; hit_idx = '0;
    ex_any = 1'b0; ex_idx = '0;
    free_any = 1'b0; free_idx = '0;
    old_idx = '0; old_age = '0;
    for (int i = 0; i < STREAMS; i++) begin
      if (t_val[i] && t_pg[i] == d_pg) begin
        if (!hit_any && (t_dir[i] ? ({2'b00, t_dem[i]} == d_off + ONE)
                                  : ({2'b00, t_dem[i]} + ONE == d_off))) begin
          hit_any = 1'b1;
          hit_idx = IDX_W'(i);
        end
        if (!ex_any && t_dir[i] == adj_dn) begin
          ex_any = 1'b1;
          ex_idx = IDX_W'(i);
        end
      end
      if (!t_val[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (t_val[i] && t_age[i] > old_age) begin
        old_age = t_age[i];
        old_idx = IDX_W'(i);
      end
    end
  end

  logic             alloc, act, s_dir, heavy;
  logic [IDX_W-1:0] sel;
  logic [W-1:0]     s_ptr, base, c1, c2, dist1, dist2, lim;
  logic             in1, in2, ok1, ok2, llc1, llc2;
  logic [LINE_W-1:0] line1, line2;

  assign alloc = dmd_valid && !hit_any && (adj_up || adj_dn);
  assign act   = (dmd_valid && hit_any) || alloc;
  assign sel   = hit_any ? hit_idx : ex_any ? ex_idx : free_any ? free_idx : old_idx;
  assign s_dir = hit_any ? t_dir[hit_idx] : adj_dn;
  assign s_ptr = hit_any ? {2'b00, t_ptr[hit_idx]} : d_off;
  assign base  = s_dir ? ((s_ptr < d_off) ? s_ptr : d_off)
                       : ((s_ptr > d_off) ? s_ptr : d_off);
  assign c1    = s_dir ? base - ONE : base + ONE;
  assign c2    = s_dir ? base - TWO : base + TWO;
  assign in1   = s_dir ? (base >= ONE) : (c1 <= TOP);
  assign in2   = s_dir ? (base >= TWO) : (c2 <= TOP);
  assign dist1 = s_dir ? d_off - c1 : c1 - d_off;
  assign dist2 = s_dir ? d_off - c2 : c2 - d_off;
  assign heavy = outst_cnt >= THR_H;
  assign lim   = heavy ? LIM_H : (outst_cnt >= THR_M) ? LIM_M : LIM_L;
  assign ok1   = act && in1 && dist1 <= lim;
  assign ok2   = ok1 && in2 && dist2 <= lim;
  assign llc1  = heavy || dist1 > FAR;
  assign llc2  = heavy || dist2 > FAR;
  assign line1 = {d_pg, c1[OFF_W-1:0]};
  assign line2 = {d_pg, c2[OFF_W-1:0]};

  logic              pop, s_v0, s_v1, s_l0;
  logic [LINE_W-1:0] s_ln0;
  logic              n_v0, n_v1, n_l0, n_l1;
  logic [LINE_W-1:0] n_ln0, n_ln1;
  logic [1:0]        take;
  logic [OFF_W-1:0]  n_ptr;

  always_comb begin
    pop   = q_v0 && pf_ready;
    s_v0  = pop ? q_v1 : q_v0;
    s_ln0 = pop ? q_ln1 : q_ln0;
    s_l0  = pop ? q_l1 : q_l0;
    s_v1  = pop ? 1'b0 : q_v1;
    n_v0 = s_v0; n_ln0 = s_ln0; n_l0 = s_l0;
    n_v1 = s_v1; n_ln1 = q_ln1; n_l1 = q_l1;
    take = 2'd0;
    if (ok1 && !s_v1) begin
      take = 2'd1;
      if (!s_v0) begin
        n_v0 = 1'b1; n_ln0 = line1; n_l0 = llc1;
        if (ok2) begin
          n_v1 = 1'b1; n_ln1 = line2; n_l1 = llc2;
          take = 2'd2;
        end
      end else begin
        n_v1 = 1'b1; n_ln1 = line1; n_l1 = llc1;
      end
    end
  end

  assign n_ptr = (take == 2'd2) ? c2[OFF_W-1:0] :
                 (take == 2'd1) ? c1[OFF_W-1:0] : base[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      last_v <= 1'b0; last_line <= '0;
      q_v0 <= 1'b0; q_v1 <= 1'b0; q_l0 <= 1'b0; q_l1 <= 1'b0;
      q_ln0 <= '0; q_ln1 <= '0;
      for (int i = 0; i < STREAMS; i++) begin
        t_val[i] <= 1'b0; t_pg[i] <= '0; t_dir[i] <= 1'b0;
        t_dem[i] <= '0; t_ptr[i] <= '0; t_age[i] <= '0;
      end
    end else begin
      q_v0 <= n_v0; q_ln0 <= n_ln0; q_l0 <= n_l0;
      q_v1 <= n_v1; q_ln1 <= n_ln1; q_l1 <= n_l1;
      if (dmd_valid) begin
        last_v <= 1'b1;
        last_line <= dmd_line;
      end
      if (act) begin
        for (int i = 0; i < STREAMS; i++) begin
          if (IDX_W'(i) == sel) begin
            t_val[i] <= 1'b1;
            t_pg[i]  <= d_pg;
            t_dir[i] <= s_dir;
            t_dem[i] <= d_off[OFF_W-1:0];
            t_ptr[i] <= n_ptr;
            t_age[i] <= '0;
          end else if (t_val[i] && t_age[i] != AGE_MAX) begin
            t_age[i] <= t_age[i] + 1'b1;
          end
        end
      end
    end
  end

  assign pf_valid    = q_v0;
  assign pf_line     = q_ln0;
  assign pf_llc_only = q_l0;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int LINE_W     = 30,
  parameter int PAGE_LINES = 64,
  parameter int CNT_W      = 6,
  parameter int LOAD_HEAVY = 12,
  parameter int DIST_LIGHT = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              dmd_valid,
  input logic [LINE_W-1:0] dmd_line,
  input logic [CNT_W-1:0]  outst_cnt,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [LINE_W-1:0] pf_line,
  input logic              pf_llc_only
);
  localparam int OFF_W = $clog2(PAGE_LINES);
  localparam logic [CNT_W-1:0]  THR_H = CNT_W'(LOAD_HEAVY);
  localparam logic [LINE_W-1:0] LIM   = LINE_W'(DIST_LIGHT);

  logic [LINE_W-1:0] prev_line;
  logic [LINE_W-1:0] gap;
  always_ff @(posedge clk) prev_line <= dmd_line;
  assign gap = (pf_line >= prev_line) ? pf_line - prev_line : prev_line - pf_line;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pf_valid);

  p_from_demand_r10: assert property (@(posedge clk) disable iff (rst)
    (!dmd_valid && !pf_valid) |=> !pf_valid);

  p_same_page_r4: assert property (@(posedge clk) disable iff (rst)
    (dmd_valid && !pf_valid) |=>
      (!pf_valid || pf_line[LINE_W-1:OFF_W] == prev_line[LINE_W-1:OFF_W]));

  p_lead_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (dmd_valid && !pf_valid) |=> (!pf_valid || (gap != '0 && gap <= LIM)));

  p_heavy_llc_r6: assert property (@(posedge clk) disable iff (rst)
    (dmd_valid && outst_cnt >= THR_H && !pf_valid) |=> (!pf_valid || pf_llc_only));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line) && $stable(pf_llc_only)));
endmodule

bind stream_prefetcher sp_checker #(
  .LINE_W(LINE_W), .PAGE_LINES(PAGE_LINES), .CNT_W(CNT_W),
  .LOAD_HEAVY(LOAD_HEAVY), .DIST_LIGHT(DIST_LIGHT)
) u_chk (.*);

// File: tb/tb_stream_prefetcher.sv
`timescale 1ns/1ps
module tb_stream_prefetcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dmd_valid = 1'b0;
  logic [29:0] dmd_line = '0;
  logic [5:0]  outst_cnt = '0;
  logic        pf_valid, pf_llc_only;
  logic        pf_ready = 1'b1;
  logic [29:0] pf_line;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  stream_prefetcher dut (
    .clk(clk), .rst(rst), .dmd_valid(dmd_valid), .dmd_line(dmd_line),
    .outst_cnt(outst_cnt), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_line(pf_line), .pf_llc_only(pf_llc_only)
  );

  typedef struct packed {
    logic [29:0] ln;
    logic [5:0]  oc;
    logic [1:0]  n;
    logic [29:0] a;
    logic        al;
    logic [29:0] b;
    logic        bl;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{30'h4000, 6'd0,  2'd0, 30'h0,    1'b0, 30'h0,    1'b0},  // R2 lone demand
    '{30'h4001, 6'd0,  2'd2, 30'h4002, 1'b0, 30'h4003, 1'b0},  // R2 ascending open
    '{30'h4002, 6'd0,  2'd2, 30'h4004, 1'b0, 30'h4005, 1'b0},  // R3 hit
    '{30'h4003, 6'd15, 2'd2, 30'h4006, 1'b1, 30'h4007, 1'b1},  // R6 heavy load
    '{30'h4004, 6'd15, 2'd1, 30'h4008, 1'b1, 30'h0,    1'b0},  // R5 heavy limit 4
    '{30'h4005, 6'd15, 2'd1, 30'h4009, 1'b1, 30'h0,    1'b0},  // R5
    '{30'h4006, 6'd6,  2'd2, 30'h400A, 1'b0, 30'h400B, 1'b0},  // R5 moderate
    '{30'h8010, 6'd0,  2'd0, 30'h0,    1'b0, 30'h0,    1'b0},  // R2 other page
    '{30'h800F, 6'd0,  2'd2, 30'h800E, 1'b0, 30'h800D, 1'b0},  // R2 descending open
    '{30'h800E, 6'd0,  2'd2, 30'h800C, 1'b0, 30'h800B, 1'b0},  // R3 descending hit
    '{30'hC03C, 6'd0,  2'd0, 30'h0,    1'b0, 30'h0,    1'b0},  // R2
    '{30'hC03D, 6'd0,  2'd2, 30'hC03E, 1'b0, 30'hC03F, 1'b0},  // R4 last two lines
    '{30'hC03E, 6'd0,  2'd0, 30'h0,    1'b0, 30'h0,    1'b0},  // R4 page end
    '{30'h4020, 6'd0,  2'd0, 30'h0,    1'b0, 30'h0,    1'b0},  // R7
    '{30'h401F, 6'd0,  2'd2, 30'h401E, 1'b0, 30'h401D, 1'b0},  // R7 second direction
    '{30'h4007, 6'd0,  2'd2, 30'h400C, 1'b0, 30'h400D, 1'b0},  // R7 ascending alive
    '{30'h4008, 6'd0,  2'd2, 30'h400E, 1'b0, 30'h400F, 1'b0},  // R3
    '{30'h4009, 6'd0,  2'd2, 30'h4010, 1'b0, 30'h4011, 1'b0},  // R3
    '{30'h400A, 6'd0,  2'd2, 30'h4012, 1'b0, 30'h4013, 1'b0},  // R3
    '{30'h400B, 6'd0,  2'd2, 30'h4014, 1'b0, 30'h4015, 1'b0},  // R3
    '{30'h400C, 6'd0,  2'd2, 30'h4016, 1'b0, 30'h4017, 1'b1}   // R6 far cutoff
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [29:0] ln, input logic [5:0] oc, input int en,
                      input logic [29:0] ea, input logic al,
                      input logic [29:0] eb, input logic bl, input string req);
    int got, first_k;
    logic [29:0] ga, gb;
    logic gal, gbl;
    got = 0; first_k = -1; ga = '0; gb = '0; gal = 1'b0; gbl = 1'b0;
    @(negedge clk);
    dmd_valid = 1'b1; dmd_line = ln; outst_cnt = oc;
    @(negedge clk);
    dmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (pf_valid) begin
        if (got == 0) begin ga = pf_line; gal = pf_llc_only; first_k = k; end
        else if (got == 1) begin gb = pf_line; gbl = pf_llc_only; end
        got++;
      end
      @(negedge clk);
    end
    check(got == en, req, "prefetch count", got, en);
    if (en > 0) begin
      check(first_k == 0, "R10", "first prefetch cycle", first_k, 0);
      check(ga == ea, req, "first line", ga, ea);
      check(gal == al, req, "first level flag", gal, al);
    end
    if (en > 1) begin
      check(gb == eb, req, "second line", gb, eb);
      check(gbl == bl, req, "second level flag", gbl, bl);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(pf_valid == 1'b0, "R1", "pf_valid after reset", pf_valid, 0);

    for (int v = 0; v < NV; v++)
      step(VEC[v].ln, VEC[v].oc, int'(VEC[v].n), VEC[v].a, VEC[v].al,
           VEC[v].b, VEC[v].bl, "table");

    // R5 light-load run-ahead up to 20 lines, beyond 10 marked last-level only (R6)
    for (int k = 13; k <= 21; k++)
      step(30'h4000 + 30'(k), 6'd0, 2, 30'h4000 + 30'(2*k-2), 1'b1,
           30'h4000 + 30'(2*k-1), 1'b1, "R5");
    step(30'h4016, 6'd0, 1, 30'h402A, 1'b1, 30'h0, 1'b0, "R5");
    step(30'h4017, 6'd0, 1, 30'h402B, 1'b1, 30'h0, 1'b0, "R5");
    step(30'h4018, 6'd15, 0, 30'h0, 1'b0, 30'h0, 1'b0, "R5");
    step(30'h4019, 6'd0, 2, 30'h402C, 1'b1, 30'h402D, 1'b1, "R5");

    // R9 backpressure, holding register and dropped candidates
    pf_ready = 1'b0;
    @(negedge clk); dmd_valid = 1'b1; dmd_line = 30'h10000; outst_cnt = 6'd0;
    @(negedge clk); dmd_line = 30'h10001;
    @(negedge clk); dmd_valid = 1'b0;
    check(pf_valid && pf_line == 30'h10002, "R9", "head while stalled", pf_line, 30'h10002);
    repeat (3) @(negedge clk);
    check(pf_valid && pf_line == 30'h10002, "R9", "head held", pf_line, 30'h10002);
    dmd_valid = 1'b1; dmd_line = 30'h10002;
    @(negedge clk); dmd_valid = 1'b0;
    check(pf_valid && pf_line == 30'h10002, "R9", "head after full demand", pf_line, 30'h10002);
    pf_ready = 1'b1;
    @(negedge clk);
    check(pf_valid && pf_line == 30'h10003, "R9", "held request", pf_line, 30'h10003);
    @(negedge clk);
    check(pf_valid == 1'b0, "R9", "no dropped request", pf_valid, 0);
    step(30'h10003, 6'd0, 2, 30'h10004, 1'b0, 30'h10005, 1'b0, "R9");

    // R5 moderate load: at most 10 ahead, exactly 10 is not last-level only
    for (int k = 4; k <= 11; k++)
      step(30'h10000 + 30'(k), 6'd6, 2, 30'h10000 + 30'(2*k-2), 1'b0,
           30'h10000 + 30'(2*k-1), 1'b0, "R5");
    step(30'h1000C, 6'd6, 1, 30'h10016, 1'b0, 30'h0, 1'b0, "R5");
    step(30'h1000D, 6'd6, 1, 30'h10017, 1'b0, 30'h0, 1'b0, "R5");

    // R8 fill the table, then one more stream replaces the least recently used
    for (int p = 0; p < 27; p++) begin
      step(30'(32'h500 + p) << 6, 6'd0, 0, 30'h0, 1'b0, 30'h0, 1'b0, "R8");
      step((30'(32'h500 + p) << 6) + 30'd1, 6'd0, 2, (30'(32'h500 + p) << 6) + 30'd2, 1'b0,
           (30'(32'h500 + p) << 6) + 30'd3, 1'b0, "R8");
    end
    step(30'h18000, 6'd0, 0, 30'h0, 1'b0, 30'h0, 1'b0, "R8");
    step(30'h18001, 6'd0, 2, 30'h18002, 1'b0, 30'h18003, 1'b0, "R8");
    step(30'h800D, 6'd0, 0, 30'h0, 1'b0, 30'h0, 1'b0, "R8");
    step(30'h401E, 6'd0, 2, 30'h401C, 1'b0, 30'h401B, 1'b0, "R8");

    // R1 reset clears the table and the remembered demand
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check(pf_valid == 1'b0, "R1", "pf_valid after second reset", pf_valid, 0);
    step(30'h401D, 6'd0, 0, 30'h0, 1'b0, 30'h0, 1'b0, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule